// File: doc/BRIEF.md
# Display DMA Descriptor Loader

This block serves a display controller with up to seven DMA channels. When a frame begins, the controller pulses `start_i`, and the block then visits the channels one at a time, in ascending index order. For every enabled channel it chooses a descriptor pointer. That pointer is a pending branch target when the channel's branch register asks for one. Otherwise it is the chained next-descriptor pointer. The block then confirms that the whole 16-byte descriptor lies inside either the main-memory window or the internal-memory window. If it does, the block reads four 32-bit words through a single-outstanding memory read port.

The four words arrive at ascending addresses and are stored as the channel's next pointer, frame source address, frame ID and command word. The fetched source address is then validated. A source of zero, or one that lies outside both windows, produces a bus-error pulse tagged with the channel number. A branch that is taken with its interrupt bit set produces a one-cycle branch event on that channel's line. The pass ends with a one-cycle done pulse.

Software-side register access is reduced to two write ports (branch, next pointer) and a combinational read port that selects one stored field of one channel.

Top module: `desc_fetch`

## Requirements
- R1: A branch write stores `wdata & 32'hFFFF_FFF3`. Bit 0 is branch-pending, bit 1 is branch-interrupt-enable, and bits 31:4 are the branch descriptor address.
- R2: A next-pointer write stores the data with bits 3:0 forced to zero.
- R3: Starting a pass clears the source address of every channel. A channel whose enable bit is low is skipped: it issues no memory read and raises no event, and its pending branch stays set.
- R4: For an enabled channel with branch-pending set, the descriptor is read from `{branch[31:4],4'b0}`. Branch-pending is then cleared, and the other branch bits are kept.
- R5: Taking a branch raises `branch_evt_o[ch]` for one cycle only if the channel's branch-interrupt-enable bit is set. At most one event bit is high at a time.
- R6: Without a pending branch, the descriptor is read from the channel's next-pointer register. That register was written by software or loaded by the previous pass, so successive passes follow the chain.
- R7: When the 16-byte span starting at the descriptor pointer is not wholly inside `[MAIN_BASE, MAIN_BASE+MAIN_SIZE)` or `[INTL_BASE, INTL_BASE+INTL_SIZE)`, no read is issued and the channel's source stays zero.
- R8: A descriptor is read at pointer +0, +4, +8, +12, in that order. The words are stored as next pointer, source, frame ID and command respectively. The read-port select codes are 0 next, 1 source, 2 ID, 3 command, 4 branch.
- R9: After loading, an enabled channel whose source is zero, or whose source address lies in neither window, raises `berr_o` for one cycle with `berr_ch_o` equal to the channel number.
- R10: Channels are handled in ascending order. Every pass ends with exactly one single-cycle `done_o` pulse, after which `busy_o` is low.
- R11: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` is seen. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start; begins a load pass when idle |
| chan_en_i | input | NCH | Per-channel enable |
| br_we_i | input | 1 | Branch register write strobe |
| br_ch_i | input | CW | Branch write channel |
| br_wdata_i | input | 32 | Branch write data |
| nd_we_i | input | 1 | Next-pointer write strobe |
| nd_ch_i | input | CW | Next-pointer write channel |
| nd_wdata_i | input | 32 | Next-pointer write data |
| rd_ch_i | input | CW | Read port channel |
| rd_sel_i | input | 3 | Read port field select |
| rd_data_o | output | 32 | Selected field |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| branch_evt_o | output | NCH | Per-channel branch event pulse |
| berr_o | output | 1 | Bus-error pulse |
| berr_ch_o | output | CW | Channel of the bus error |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Pass complete pulse |

## Verification
The assertions assume a memory that raises `mem_rvalid_i` only while `mem_req_o` is high, for exactly one cycle per read, with data for the address being held. The bench's memory model follows this rule and varies its response latency between zero and two cycles. The assertions also assume that the write ports and `start_i` are quiet during a pass. The bench therefore issues register writes only while `busy_o` is low, and pulses `start_i` only between passes.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  localparam int BR_PEND = 0;
  localparam int BR_INT  = 1;
  localparam logic [31:0] BR_KEEP = 32'hFFFF_FFF3;
  localparam logic [31:0] ND_KEEP = 32'hFFFF_FFF0;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_FETCH, ST_CHECK, ST_NEXT
  } fetch_st_e;

  typedef enum logic [2:0] {
    SEL_NEXT = 3'd0, SEL_SRC = 3'd1, SEL_ID = 3'd2, SEL_CMD = 3'd3, SEL_BRANCH = 3'd4
  } rd_sel_e;
endpackage

// File: rtl/desc_fetch_win.sv
module desc_fetch_win #(
  parameter logic [31:0] A_BASE = 32'h0,
  parameter logic [31:0] A_SIZE = 32'h1000,
  parameter logic [31:0] B_BASE = 32'h2000,
  parameter logic [31:0] B_SIZE = 32'h1000,
  parameter int          SPAN   = 1
) (
  input  logic [31:0] addr_i,
  output logic        ok_o
);
  localparam logic [32:0] A_END = {1'b0, A_BASE} + {1'b0, A_SIZE};
  localparam logic [32:0] B_END = {1'b0, B_BASE} + {1'b0, B_SIZE};
  localparam logic [32:0] SPAN_W = 33'(SPAN);

  logic [32:0] lo, hi;
  assign lo = {1'b0, addr_i};
  assign hi = lo + SPAN_W;
  assign ok_o = (lo >= {1'b0, A_BASE} && hi <= A_END) ||
                (lo >= {1'b0, B_BASE} && hi <= B_END);
endmodule

// File: rtl/desc_fetch_regs.sv
module desc_fetch_regs import desc_fetch_pkg::*; #(
  parameter int NCH = 7,
  parameter int CW  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  br_we_i,
  input  logic [CW-1:0]         br_ch_i,
  input  logic [31:0]           br_wdata_i,
  input  logic                  nd_we_i,
  input  logic [CW-1:0]         nd_ch_i,
  input  logic [31:0]           nd_wdata_i,
  input  logic                  clr_src_i,
  input  logic                  br_ack_i,
  input  logic                  ld_we_i,
  input  logic [CW-1:0]         ld_ch_i,
  input  logic [1:0]            ld_idx_i,
  input  logic [31:0]           ld_data_i,
  output logic [NCH-1:0][31:0]  br_o,
  output logic [NCH-1:0][31:0]  nd_o,
  output logic [NCH-1:0][31:0]  src_o,
  output logic [NCH-1:0][31:0]  id_o,
  output logic [NCH-1:0][31:0]  cmd_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_br, sel_nd, sel_ld;
    assign sel_br = br_we_i && (br_ch_i == CW'(g));
    assign sel_nd = nd_we_i && (nd_ch_i == CW'(g));
    assign sel_ld = ld_we_i && (ld_ch_i == CW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        br_o[g]  <= '0;
        nd_o[g]  <= '0;
        src_o[g] <= '0;
        id_o[g]  <= '0;
        cmd_o[g] <= '0;
      end else begin
        if (sel_br) br_o[g] <= br_wdata_i & BR_KEEP;
        // taking a branch drops only the pending flag
        if (br_ack_i && ld_ch_i == CW'(g)) br_o[g][BR_PEND] <= 1'b0;
        if (sel_nd) nd_o[g] <= nd_wdata_i & ND_KEEP;
        if (clr_src_i) src_o[g] <= '0;
        if (sel_ld) begin
          case (ld_idx_i)
            2'd0: nd_o[g]  <= ld_data_i;
            2'd1: src_o[g] <= ld_data_i;
            2'd2: id_o[g]  <= ld_data_i;
            default: cmd_o[g] <= ld_data_i;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/desc_fetch.sv
module desc_fetch import desc_fetch_pkg::*; #(
  parameter int          NCH       = 7,
  parameter logic [31:0] MAIN_BASE = 32'hA000_0000,
  parameter logic [31:0] MAIN_SIZE = 32'h0400_0000,
  parameter logic [31:0] INTL_BASE = 32'h5C00_0000,
  parameter logic [31:0] INTL_SIZE = 32'h0004_0000,
  localparam int         CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NCH-1:0]  chan_en_i,
  input  logic            br_we_i,
  input  logic [CW-1:0]   br_ch_i,
  input  logic [31:0]     br_wdata_i,
  input  logic            nd_we_i,
  input  logic [CW-1:0]   nd_ch_i,
  input  logic [31:0]     nd_wdata_i,
  input  logic [CW-1:0]   rd_ch_i,
  input  logic [2:0]      rd_sel_i,
  output logic [31:0]     rd_data_o,
  output logic            mem_req_o,
  output logic [31:0]     mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [31:0]     mem_rdata_i,
  output logic [NCH-1:0]  branch_evt_o,
  output logic            berr_o,
  output logic [CW-1:0]   berr_ch_o,
  output logic            busy_o,
  output logic            done_o
);
  fetch_st_e     st_q;
  logic [CW-1:0] ch_q;
  logic [1:0]    widx_q;
  logic [31:0]   ptr_q;

  logic [NCH-1:0][31:0] br_q, nd_q, src_q, id_q, cmd_q;
  logic [31:0] pick_ptr, cur_src;
  logic        ch_en, br_pend, br_ack, clr_src, ld_we, desc_ok, src_ok;

  assign ch_en    = chan_en_i[ch_q];
  assign br_pend  = br_q[ch_q][BR_PEND];
  assign pick_ptr = br_pend ? {br_q[ch_q][31:4], 4'b0000} : nd_q[ch_q];
  assign cur_src  = src_q[ch_q];
  assign br_ack   = (st_q == ST_PICK) && ch_en && br_pend;
  assign clr_src  = (st_q == ST_IDLE) && start_i;
  assign ld_we    = (st_q == ST_FETCH) && mem_rvalid_i;

  assign mem_req_o  = (st_q == ST_FETCH);
  assign mem_addr_o = ptr_q + {28'd0, widx_q, 2'b00};
  assign busy_o     = (st_q != ST_IDLE);

  desc_fetch_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .br_we_i, .br_ch_i, .br_wdata_i,
    .nd_we_i, .nd_ch_i, .nd_wdata_i,
    .clr_src_i (clr_src),
    .br_ack_i  (br_ack),
    .ld_we_i   (ld_we),
    .ld_ch_i   (ch_q),
    .ld_idx_i  (widx_q),
    .ld_data_i (mem_rdata_i),
    .br_o (br_q), .nd_o (nd_q), .src_o (src_q), .id_o (id_q), .cmd_o (cmd_q)
  );

  desc_fetch_win #(.A_BASE(MAIN_BASE), .A_SIZE(MAIN_SIZE), .B_BASE(INTL_BASE),
                   .B_SIZE(INTL_SIZE), .SPAN(DESC_BYTES)) u_desc_win (
    .addr_i (pick_ptr), .ok_o (desc_ok));

  desc_fetch_win #(.A_BASE(MAIN_BASE), .A_SIZE(MAIN_SIZE), .B_BASE(INTL_BASE),
                   .B_SIZE(INTL_SIZE), .SPAN(1)) u_src_win (
    .addr_i (cur_src), .ok_o (src_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      ch_q         <= '0;
      widx_q       <= '0;
      ptr_q        <= '0;
      branch_evt_o <= '0;
      berr_o       <= 1'b0;
      berr_ch_o    <= '0;
      done_o       <= 1'b0;
    end else begin
      branch_evt_o <= '0;
      berr_o       <= 1'b0;
      done_o       <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          ch_q <= '0;
          st_q <= ST_PICK;
        end
        ST_PICK: begin
          if (!ch_en) begin
            st_q <= ST_NEXT;
          end else begin
            ptr_q  <= pick_ptr;
            widx_q <= '0;
            if (br_pend && br_q[ch_q][BR_INT]) branch_evt_o[ch_q] <= 1'b1;
            st_q <= desc_ok ? ST_FETCH : ST_CHECK;
          end
        end
        ST_FETCH: if (mem_rvalid_i) begin
          if (widx_q == 2'd3) st_q <= ST_CHECK;
          else widx_q <= widx_q + 2'd1;
        end
        ST_CHECK: begin
          if (cur_src == '0 || !src_ok) begin
            berr_o    <= 1'b1;
            berr_ch_o <= ch_q;
          end
          st_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (ch_q == CW'(NCH - 1)) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            ch_q <= ch_q + CW'(1);
            st_q <= ST_PICK;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_ch_i <= CW'(NCH - 1)) begin
      case (rd_sel_e'(rd_sel_i))
        SEL_NEXT:   rd_data_o = nd_q[rd_ch_i];
        SEL_SRC:    rd_data_o = src_q[rd_ch_i];
        SEL_ID:     rd_data_o = id_q[rd_ch_i];
        SEL_CMD:    rd_data_o = cmd_q[rd_ch_i];
        SEL_BRANCH: rd_data_o = br_q[rd_ch_i];
        default:    rd_data_o = '0;
      endcase
    end
  end

  localparam logic [32:0] MAIN_END = {1'b0, MAIN_BASE} + {1'b0, MAIN_SIZE};
  localparam logic [32:0] INTL_END = {1'b0, INTL_BASE} + {1'b0, INTL_SIZE};
  logic req_in_win;
  assign req_in_win = (mem_addr_o >= MAIN_BASE && {1'b0, mem_addr_o} < MAIN_END) ||
                      (mem_addr_o >= INTL_BASE && {1'b0, mem_addr_o} < INTL_END);

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  assert_req_in_win_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> req_in_win);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_evt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(branch_evt_o));
  assert_berr_ch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> berr_ch_o <= CW'(NCH - 1));
  assert_no_event_mix_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !berr_o && branch_evt_o == '0);
endmodule

// File: tb/desc_fetch_bench.sv
`timescale 1ns/1ps
module desc_fetch_bench;
  localparam int NCH = 7;
  localparam int CW  = 3;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic start = 0;
  logic [NCH-1:0] en = '0;
  logic br_we = 0, nd_we = 0;
  logic [CW-1:0] br_ch = '0, nd_ch = '0, rd_ch = '0;
  logic [31:0] br_wd = '0, nd_wd = '0;
  logic [2:0] rd_sel = '0;
  logic [31:0] rd_data, mem_addr, rdata = '0;
  logic mem_req, rvalid = 0;
  logic [NCH-1:0] bevt;
  logic berr, busy, done;
  logic [CW-1:0] berr_ch;

  desc_fetch u_desc_fetch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_en_i(en),
    .br_we_i(br_we), .br_ch_i(br_ch), .br_wdata_i(br_wd),
    .nd_we_i(nd_we), .nd_ch_i(nd_ch), .nd_wdata_i(nd_wd),
    .rd_ch_i(rd_ch), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .branch_evt_o(bevt), .berr_o(berr), .berr_ch_o(berr_ch), .busy_o(busy), .done_o(done));

  int checks = 0, failures = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] m_br[NCH], m_nd[NCH], m_src[NCH], m_id[NCH], m_cmd[NCH];
  logic [31:0] q_addr[$];
  int q_bevt[$], q_berr[$];
  int done_cnt = 0, wait_cnt = 0, lat = 0;
  logic [31:0] held_addr = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic bit in_win(logic [31:0] a, int span);
    longint lo = longint'(a);
    longint hi = lo + span;
    return (lo >= 64'hA000_0000 && hi <= 64'hA400_0000) ||
           (lo >= 64'h5C00_0000 && hi <= 64'h5C04_0000);
  endfunction

  task automatic put_desc(logic [31:0] a, logic [31:0] w0, w1, w2, w3);
    mem[a] = w0; mem[a+4] = w1; mem[a+8] = w2; mem[a+12] = w3;
  endtask

  // memory responder and per-clock monitor
  always @(negedge clk) begin
    if (rvalid) rvalid = 0;
    else if (mem_req) begin
      if (wait_cnt == 0) held_addr = mem_addr;
      else chk("R11", mem_addr, held_addr, "address moved while waiting");
      if (wait_cnt >= lat) begin
        if (q_addr.size() == 0) chk("R8", mem_addr, 32'hxxxx_xxxx, "unexpected read");
        else chk("R8", mem_addr, q_addr.pop_front(), "read address");
        rdata = mrd(mem_addr);
        rvalid = 1;
        wait_cnt = 0;
        lat = (lat + 1) % 3;
      end else wait_cnt++;
    end
    for (int c = 0; c < NCH; c++) if (bevt[c]) begin
      if (q_bevt.size() == 0) chk("R5", c, 32'hFFFF_FFFF, "unexpected branch event");
      else chk("R5", c, q_bevt.pop_front(), "branch event channel");
    end
    if (berr) begin
      if (q_berr.size() == 0) chk("R9", 32'(berr_ch), 32'hFFFF_FFFF, "unexpected bus error");
      else chk("R9", 32'(berr_ch), q_berr.pop_front(), "bus error channel");
    end
    if (done) done_cnt++;
  end

  task automatic wr_br(int c, logic [31:0] v);
    @(negedge clk); br_we = 1; br_ch = CW'(c); br_wd = v;
    @(negedge clk); br_we = 0;
    m_br[c] = v & 32'hFFFF_FFF3;
  endtask

  task automatic wr_nd(int c, logic [31:0] v);
    @(negedge clk); nd_we = 1; nd_ch = CW'(c); nd_wd = v;
    @(negedge clk); nd_we = 0;
    m_nd[c] = v & 32'hFFFF_FFF0;
  endtask

  task automatic rd(int c, int sel, output logic [31:0] v);
    rd_ch = CW'(c); rd_sel = 3'(sel); #1; v = rd_data;
  endtask

  task automatic check_regs(string tag);
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd(c, 0, v); chk("R6", v, m_nd[c], {tag, " next pointer"});
      rd(c, 1, v); chk("R3", v, m_src[c], {tag, " source"});
      rd(c, 2, v); chk("R8", v, m_id[c], {tag, " frame id"});
      rd(c, 3, v); chk("R8", v, m_cmd[c], {tag, " command"});
      rd(c, 4, v); chk("R4", v, m_br[c], {tag, " branch"});
    end
  endtask

  task automatic run_pass(logic [NCH-1:0] e, string tag);
    logic [31:0] p;
    int d0;
    for (int c = 0; c < NCH; c++) m_src[c] = 0;
    for (int c = 0; c < NCH; c++) begin
      if (!e[c]) continue;
      if (m_br[c][0]) begin
        p = {m_br[c][31:4], 4'h0};
        m_br[c][0] = 1'b0;
        if (m_br[c][1]) q_bevt.push_back(c);
      end else p = m_nd[c];
      if (in_win(p, 16)) begin
        for (int k = 0; k < 4; k++) q_addr.push_back(p + 32'(4*k));
        m_nd[c] = mrd(p); m_src[c] = mrd(p+4); m_id[c] = mrd(p+8); m_cmd[c] = mrd(p+12);
      end
      if (m_src[c] == 0 || !in_win(m_src[c], 1)) q_berr.push_back(c);
    end
    d0 = done_cnt;
    @(negedge clk); en = e; start = 1;
    @(negedge clk); start = 0;
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10", done_cnt - d0, 1, {tag, " done pulses"});
    chk("R10", 32'(busy), 0, {tag, " busy after done"});
    chk("R8", q_addr.size(), 0, {tag, " reads missing"});
    chk("R5", q_bevt.size(), 0, {tag, " branch events missing"});
    chk("R9", q_berr.size(), 0, {tag, " bus errors missing"});
    q_addr.delete(); q_bevt.delete(); q_berr.delete();
    check_regs(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      m_br[c] = 0; m_nd[c] = 0; m_src[c] = 0; m_id[c] = 0; m_cmd[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R10", {done, busy, mem_req, berr}, 0, "reset outputs");
    chk("R5", 32'(bevt), 0, "reset events");
    rst_n = 1;
    @(negedge clk);
    check_regs("reset");

    // R1 / R2 write masking
    wr_br(0, 32'hFFFF_FFFC); rd(0, 4, v); chk("R1", v, 32'hFFFF_FFF0, "branch mask");
    wr_br(0, 32'h0);
    wr_nd(0, 32'hA000_010F); rd(0, 0, v); chk("R2", v, 32'hA000_0100, "next mask");

    put_desc(32'hA000_0100, 32'hA000_0200, 32'hA010_0000, 32'h11, 32'h0060_0400);
    put_desc(32'hA000_0400, 32'hA000_0500, 32'h5C00_1000, 32'h22, 32'h0);
    put_desc(32'hA000_0600, 32'h0, 32'hA020_0000, 32'h33, 32'h0400_0010);
    put_desc(32'hA000_0700, 32'hA000_0800, 32'h0, 32'h44, 32'h0);
    put_desc(32'h5C00_0040, 32'h0, 32'h8000_0000, 32'h55, 32'h0);
    put_desc(32'hA000_0500, 32'hA000_0600, 32'hA030_0000, 32'h66, 32'h0);
    put_desc(32'hA000_0900, 32'h0, 32'h5C03_FFFC, 32'h77, 32'h0);
    put_desc(32'h5C03_FFF0, 32'hA3FF_FFF0, 32'h5C04_0000, 32'h88, 32'h0);
    put_desc(32'hA3FF_FFF0, 32'h5C04_0000, 32'hA3FF_FFFF, 32'h99, 32'h0);

    wr_nd(1, 32'hA000_0300);
    wr_br(1, 32'hA000_0403);             // branch with interrupt
    wr_br(2, 32'hA000_0601);             // branch without interrupt
    wr_nd(3, 32'h1000_0000);             // descriptor outside windows
    wr_nd(4, 32'hA000_0700);             // zero source
    wr_nd(5, 32'h5C00_0040);             // source outside windows
    wr_br(6, 32'hA000_0903);             // pending, but channel disabled
    run_pass(7'b0111111, "passA");

    // R6 chaining, R3 disabled channel source cleared, R4 branch on ch6
    run_pass(7'b1000010, "passB");
    // window edges: descriptor ending exactly at internal end, source one past end
    wr_nd(0, 32'h5C03_FFF0);
    run_pass(7'b0000001, "passC");
    run_pass(7'b0000001, "passD");       // main end edge, source last byte
    run_pass(7'b0000001, "passE");       // pointer one past internal end
    run_pass(7'b0000000, "passF");       // all disabled

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule